// File: doc/BRIEF.md
# Daisy-Chain Grayscale Serial Shifter

This block keeps a 12-bit brightness level for every output of a chain of constant-current driver chips, sixteen outputs per chip, and shifts the complete set out over a serial clock and data pair. The host writes one level at a time through a channel-number port; a level of 0 turns an output off and 4095 drives it fully on. A separate grayscale sequencer raises a clear-to-send window once per grayscale cycle. The shifter sends one whole frame inside that window and then pulses a completion strobe, which the sequencer uses as its cue to latch the new data into the chips.

Host writes always land in a shadow copy. A snapshot of the shadow is taken into the live copy in the cycle before shifting begins, so a frame on the wire never mixes old and new levels. After reset the block first pushes a long run of zero bits through the chain, longer than the chain itself, and then pulses the completion strobe so that the chip registers are latched to all-off before any real frame is sent.

The controller walks six named states. `ST_FLUSH` (entered from reset) shifts zeros and moves to `ST_CLR_LATCH` after the last flush bit; `ST_CLR_LATCH` strobes completion for one cycle and goes to `ST_IDLE`. `ST_IDLE` moves to `ST_LOAD` when clear-to-send is high and the window has not yet been used. `ST_LOAD` copies shadow to live and moves to `ST_SHIFT`. `ST_SHIFT` moves to `ST_DONE` after bit 0 of channel 0; `ST_DONE` strobes completion for one cycle and returns to `ST_IDLE`.

Top module: `gs_chain_shifter`

## Requirements
- R1: While reset is held, `sck`, `sdo` and `xfer_done` are low and `busy` is high.
- R2: After reset the block shifts exactly 200 zero bits per chip (400 with the default two chips), then raises `xfer_done` for one cycle, with `busy` low from that cycle on.
- R3: A write with `wr_ch` in 0 to N*16-1 stores `wr_level` for that channel (channel 16 is output 0 of the second chip); a write with any higher `wr_ch` changes no channel's level, which shows in the next frame.
- R4: A frame is exactly 192 bits per chip; it starts with channel N*16-1 and ends with channel 0, each level sent most significant bit first, so channel c bit b is the (N*16-1-c)*12+(11-b)-th bit shifted (counting from 0).
- R5: Serial timing is SPI mode 0: `sck` is low whenever `busy` is low, `sdo` is stable while `sck` is high, and consecutive rising edges of `sck` are 2*SCK_HALF system clocks apart.
- R6: A frame starts only while `cts` is high, and at most one frame is sent per high window of `cts`; a new frame needs `cts` to go low and high again.
- R7: `xfer_done` is high for exactly one system clock after the last bit of a frame, with `sck` low in that cycle.
- R8: A write accepted while a frame is shifting does not change that frame; it appears in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one level per cycle |
| wr_ch | input | $clog2(N_CHIPS*16)+1 | Channel number of the write |
| wr_level | input | 12 | Brightness level, 0 off to 4095 full |
| cts | input | 1 | Clear-to-send window from the grayscale sequencer |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, valid at the rising edge of `sck` |
| busy | output | 1 | High while flushing, loading or shifting |
| xfer_done | output | 1 | One-cycle strobe: frame or start-up flush complete, latch may follow |

## Verification
A wrong channel or bit counter shows up as a misplaced or shifted level within the first frame after the error, since every level is decoded from its bit position on `sdo`. A stuck or mis-cleared window flag shows as a second frame inside one `cts` window, or as no frame at all, within about one frame time. A broken snapshot shows as a level written mid-frame appearing in that same frame. Clock divider faults change the spacing of `sck` rising edges from the very first flush bit.

// File: rtl/gs_pkg.sv
package gs_pkg;

    localparam int LEVEL_W       = 12;
    localparam int OUTS_PER_CHIP = 16;

    typedef enum logic [2:0] {
        ST_FLUSH     = 3'd0,
        ST_CLR_LATCH = 3'd1,
        ST_IDLE      = 3'd2,
        ST_LOAD      = 3'd3,
        ST_SHIFT     = 3'd4,
        ST_DONE      = 3'd5
    } gs_state_t;

endpackage

// File: rtl/gs_level_store.sv
module gs_level_store
    import gs_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NCH):0]       wr_ch,
    input  logic [LEVEL_W-1:0]         wr_level,
    input  logic                       snap,
    input  logic [$clog2(NCH)-1:0]     rd_ch,
    input  logic [3:0]                 rd_bit,
    output logic                       rd_val
);

    localparam int IDX_W = $clog2(NCH) + 1;

    logic [LEVEL_W-1:0] shadow [NCH];
    logic [LEVEL_W-1:0] live   [NCH];
    logic               in_range;

    assign in_range = (wr_ch < IDX_W'(NCH));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && in_range && (wr_ch == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g] <= '0;
            end else if (hit) begin
                shadow[g] <= wr_level;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[g] <= '0;
            end else if (snap) begin
                live[g] <= shadow[g];
            end
        end
    end

    logic [LEVEL_W-1:0] sel_level;
    assign sel_level = live[rd_ch];
    assign rd_val    = sel_level[rd_bit];

endmodule

// File: rtl/gs_sck_gen.sv
module gs_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic bit_end
);

    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            hi  <= ~hi;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sck     = hi;
    assign bit_end = run && hi && (cnt == CNT_LAST);

endmodule

// File: rtl/gs_chain_shifter.sv
module gs_chain_shifter
    import gs_pkg::*;
#(
    parameter int N_CHIPS        = 2,
    parameter int SCK_HALF       = 2,
    parameter int CLR_BITS_CHIP  = 200
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(N_CHIPS*16):0]            wr_ch,
    input  logic [11:0]                            wr_level,
    input  logic                                   cts,
    output logic                                   sck,
    output logic                                   sdo,
    output logic                                   busy,
    output logic                                   xfer_done
);

    localparam int NCH        = N_CHIPS * OUTS_PER_CHIP;
    localparam int CH_W       = $clog2(NCH);
    localparam int FLUSH_BITS = N_CHIPS * CLR_BITS_CHIP;
    localparam int FLUSH_W    = $clog2(FLUSH_BITS);

    gs_state_t          state_q, state_d;
    logic [FLUSH_W-1:0] flush_cnt;
    logic [CH_W-1:0]    ch_cnt;
    logic [3:0]         bpos;
    logic               armed;
    logic               run_sck;
    logic               bit_end;
    logic               snap;
    logic               live_bit;
    logic               last_bit;

    assign run_sck  = (state_q == ST_FLUSH) || (state_q == ST_SHIFT);
    assign snap     = (state_q == ST_LOAD);
    assign last_bit = (ch_cnt == '0) && (bpos == 4'd0);

    gs_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_sck),
        .sck     (sck),
        .bit_end (bit_end)
    );

    gs_level_store #(.NCH(NCH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_level (wr_level),
        .snap     (snap),
        .rd_ch    (ch_cnt),
        .rd_bit   (bpos),
        .rd_val   (live_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH:     if (bit_end && flush_cnt == '0) state_d = ST_CLR_LATCH;
            ST_CLR_LATCH: state_d = ST_IDLE;
            ST_IDLE:      if (cts && armed) state_d = ST_LOAD;
            ST_LOAD:      state_d = ST_SHIFT;
            ST_SHIFT:     if (bit_end && last_bit) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_FLUSH;
        endcase
    end

    // bit position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_cnt <= FLUSH_W'(FLUSH_BITS - 1);
            ch_cnt    <= CH_W'(NCH - 1);
            bpos      <= 4'd11;
        end else begin
            if (state_q == ST_FLUSH && bit_end) begin
                flush_cnt <= flush_cnt - 1'b1;
            end
            if (state_q == ST_LOAD) begin
                ch_cnt <= CH_W'(NCH - 1);
                bpos   <= 4'd11;
            end else if (state_q == ST_SHIFT && bit_end) begin
                if (bpos == 4'd0) begin
                    bpos   <= 4'd11;
                    ch_cnt <= ch_cnt - 1'b1;
                end else begin
                    bpos <= bpos - 1'b1;
                end
            end
        end
    end

    // one frame per clear-to-send window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (state_q == ST_LOAD) begin
            armed <= 1'b0;
        end else if (!cts) begin
            armed <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        xfer_done = 1'b0;
        sdo       = 1'b0;
        unique case (state_q)
            ST_FLUSH:     busy = 1'b1;
            ST_CLR_LATCH: xfer_done = 1'b1;
            ST_IDLE:      ;
            ST_LOAD:      busy = 1'b1;
            ST_SHIFT: begin
                busy = 1'b1;
                sdo  = live_bit;
            end
            ST_DONE:      xfer_done = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/gs_chain_shifter_chk.sv
module gs_chain_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic cts,
    input logic sck,
    input logic sdo,
    input logic busy,
    input logic xfer_done
);

    // R5
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R5
    sdo_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R7
    done_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !sck);

    // R6
    start_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cts));

endmodule

bind gs_chain_shifter gs_chain_shifter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts       (cts),
    .sck       (sck),
    .sdo       (sdo),
    .busy      (busy),
    .xfer_done (xfer_done)
);

// File: tb/gs_chain_shifter_tb.sv
module gs_chain_shifter_tb;

    localparam int N_CHIPS  = 2;
    localparam int SCK_HALF = 2;
    localparam int NCH      = N_CHIPS * 16;
    localparam int IDX_W    = $clog2(NCH) + 1;
    localparam int FRAME    = NCH * 12;
    localparam int FLUSH    = N_CHIPS * 200;

    // {channel, level}; 32 and 63 are out of range
    localparam logic [17:0] VEC [8] = '{
        {6'd31, 12'hABC}, {6'd0,  12'hFFF}, {6'd16, 12'h5A5}, {6'd1,  12'h001},
        {6'd32, 12'h777}, {6'd15, 12'h800}, {6'd31, 12'h0F0}, {6'd63, 12'h123}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [IDX_W-1:0] wr_ch;
    logic [11:0]      wr_level;
    logic             cts;
    logic             sck, sdo, busy, xfer_done;

    int n_chk  = 0;
    int n_fail = 0;

    logic        cap [0:1023];
    int          cap_n = 0;
    int          cyc = 0;
    int          last_rise = -1;
    int          gap = 0;
    logic        prev_sck = 1'b0;
    logic [11:0] exp_lvl [NCH];

    always #10 clk = ~clk;

    gs_chain_shifter #(.N_CHIPS(N_CHIPS), .SCK_HALF(SCK_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_level(wr_level), .cts(cts), .sck(sck), .sdo(sdo),
        .busy(busy), .xfer_done(xfer_done)
    );

    // capture sdo at each sck rising edge, seen between clock edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sck && !prev_sck) begin
            if (cap_n < 1024) cap[cap_n] = sdo;
            cap_n = cap_n + 1;
            if (last_rise >= 0) gap = cyc - last_rise;
            last_rise = cyc;
        end
        prev_sck = sck;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ch(input logic [IDX_W-1:0] ch, input logic [11:0] lvl);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; wr_level = lvl;
        @(negedge clk);
        wr_en = 1'b0;
        if (ch < NCH) exp_lvl[ch] = lvl;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!xfer_done && n < 20000);
        check(tag, {31'd0, xfer_done}, 32'd1);
    endtask

    function automatic logic [11:0] got_level(input int c);
        logic [11:0] v;
        for (int b = 11; b >= 0; b--) v[b] = cap[(NCH - 1 - c) * 12 + (11 - b)];
        return v;
    endfunction

    task automatic check_frame(input string tag);
        check({tag, " bit count"}, cap_n, FRAME);
        for (int c = 0; c < NCH; c++) check({tag, " level"}, got_level(c), exp_lvl[c]);
    endtask

    // one frame, with cts held high afterwards to test the window rule
    task automatic run_frame(input string tag);
        cap_n = 0;
        @(negedge clk); cts = 1'b1;
        wait_done("R7 done after frame");
        @(negedge clk);
        check("R7 done one cycle", {31'd0, xfer_done}, 32'd0);
        check("R5 sck idle low", {31'd0, sck}, 32'd0);
        repeat (600) @(negedge clk);
        // R6: no second frame in the same window
        check("R6 single frame per window", cap_n, FRAME);
        check("R6 idle in window", {31'd0, busy}, 32'd0);
        cts = 1'b0;
        @(negedge clk);
        check_frame(tag);
    endtask

    initial begin
        #4_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_level = '0; cts = 1'b0;
        for (int c = 0; c < NCH; c++) exp_lvl[c] = 12'h000;
        repeat (3) @(negedge clk);
        // R1
        check("R1 sck", {31'd0, sck}, 32'd0);
        check("R1 sdo", {31'd0, sdo}, 32'd0);
        check("R1 done", {31'd0, xfer_done}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd1);
        rst_n = 1'b1;

        // R2 start-up flush
        wait_done("R2 flush done");
        check("R2 flush bit count", cap_n, FLUSH);
        begin
            int ones = 0;
            for (int i = 0; i < FLUSH; i++) ones += int'(cap[i]);
            check("R2 flush zeros", ones, 0);
        end
        check("R2 busy low", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R7 flush strobe one cycle", {31'd0, xfer_done}, 32'd0);
        check("R5 rising edge spacing", gap, 2 * SCK_HALF);

        // R6: no frame without cts
        cap_n = 0;
        repeat (800) @(negedge clk);
        check("R6 no frame without cts", cap_n, 0);

        // R3 table of writes, one frame checks every channel (R4 order)
        for (int i = 0; i < 8; i++) write_ch(VEC[i][17:12], VEC[i][11:0]);
        run_frame("R4 R3 table");

        // R4 extremes: all-on and all-off neighbours
        write_ch(6'd30, 12'hFFF);
        write_ch(6'd29, 12'h000);
        write_ch(6'd2, 12'h555);
        run_frame("R4 extremes");

        // R8 snapshot: writes during shifting wait for the next frame
        cap_n = 0;
        @(negedge clk); cts = 1'b1;
        while (cap_n < 100) @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_ch = 6'd31; wr_level = 12'h111;
        @(negedge clk); wr_ch = 6'd0; wr_level = 12'h222;
        @(negedge clk); wr_en = 1'b0;
        wait_done("R8 done");
        @(negedge clk); cts = 1'b0;
        @(negedge clk);
        check_frame("R8 old frame");
        exp_lvl[31] = 12'h111;
        exp_lvl[0]  = 12'h222;
        run_frame("R8 next frame");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule